// File: doc/BRIEF.md
# Extension and Add/Subtract Unit

A combinational 32-bit datapath slice for a register-based processor core. Each cycle it takes an operation code, a source operand, a destination operand, an immediate with a size tag and the current carry flag. It returns the value to write back to the destination, a value for the separate multiply-high register, and fresh zero, negative, carry and overflow flags, each with its own write strobe. Decode, write-back and pipelining stay outside the block. The caller registers whatever it needs.

The operations are byte and halfword extension, signed or unsigned, and a clear. The arithmetic group is add, add-with-carry, subtract and subtract-with-borrow. A word-extend operation leaves the destination alone. Instead it fills the high register with copies of the destination's sign bit. The second arithmetic operand is either the source register or an immediate. An immediate of 8 or 16 bits is sign-extended, and a 32-bit one is used unchanged. When the destination is the stack pointer, the flags are left untouched.

Top module: `eaas_top`

## Requirements
- R1: Operation code 0 (word extend) drives `hi_val` to 0xFFFFFFFF when `dst_val[31]` is 1 and to 0x00000000 otherwise, raises `hi_we`, and holds `res_we` low.
- R2: Code 1 (signed byte) returns `dst_val[7:0]` with bit 7 copied into bits 31..8. Code 2 (unsigned byte) returns `dst_val & 0x000000FF`.
- R3: Code 3 (signed halfword) returns `dst_val[15:0]` with bit 15 copied into bits 31..16. Code 4 (unsigned halfword) returns `dst_val & 0x0000FFFF`.
- R4: Code 5 (clear) returns 0 with Z=1, N=0, C=0, V=0.
- R5: The second operand m is set by `imm_sz`: 0 selects `src_val`, 1 selects `imm_val[7:0]` sign-extended, 2 selects `imm_val[15:0]` sign-extended, and 3 selects all 32 bits of `imm_val`.
- R6: Code 6 (add) returns dst + m modulo 2^32. C is the carry out of bit 31, and `carry_in` has no effect.
- R7: Code 7 (add with carry) returns dst + m + `carry_in`, and C is the carry out of bit 31.
- R8: Code 8 (subtract) returns dst - m, never m - dst. C is 1 exactly when a borrow occurs (dst < m unsigned), and `carry_in` has no effect.
- R9: Code 9 (subtract with borrow) returns dst - m - `carry_in`. C is 1 when dst < m + `carry_in` unsigned.
- R10: For codes 6 to 9, V is 1 exactly when the true signed result lies outside the range -2^31 to 2^31-1.
- R11: For codes 0 to 5, C and V are 0. Z and N follow the written value, which for code 0 is `hi_val`.
- R12: `flag_we` is 1 for codes 0 to 9 unless `dst_sp` is 1, in which case it is 0.
- R13: `res_we` is 1 for codes 1 to 9, and `hi_we` is 1 only for code 0.
- R14: Codes 10 to 15 raise none of `res_we`, `hi_we` or `flag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (0..9 defined) |
| src_val | input | 32 | Source register operand m |
| dst_val | input | 32 | Destination register operand n |
| imm_val | input | 32 | Immediate field, low bits used for short sizes |
| imm_sz | input | 2 | 0 register, 1 imm8, 2 imm16, 3 imm32 |
| carry_in | input | 1 | Current carry flag |
| dst_sp | input | 1 | Destination is the stack pointer |
| res_val | output | 32 | Destination write value |
| res_we | output | 1 | Destination write strobe |
| hi_val | output | 32 | High register write value |
| hi_we | output | 1 | High register write strobe |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_we | output | 1 | Flag update strobe |

## Verification
The bench aims at the sign-bit edges: extension inputs whose bit 7 or bit 15 is set while the upper bits hold garbage, and immediates whose short field is negative while the unused upper bits are nonzero. A design that swaps subtract operands, inverts the borrow sense, or lets the carry leak into plain add or subtract produces wrong results or a wrong C on vectors such as 0 - 1 and 5 - 5. Overflow is driven at 0x7FFFFFFF + 1 and 0x80000000 - 1, where a wrong sign rule reports V the wrong way round. Stack-pointer destinations and unused codes catch any strobe that fires when it must stay low.

// File: rtl/eaas_pkg.sv
`timescale 1ns/1ps
package eaas_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_EXTW  = 4'd0,
    OP_EXTB  = 4'd1,
    OP_EXTBU = 4'd2,
    OP_EXTH  = 4'd3,
    OP_EXTHU = 4'd4,
    OP_CLR   = 4'd5,
    OP_ADD   = 4'd6,
    OP_ADDC  = 4'd7,
    OP_SUB   = 4'd8,
    OP_SUBC  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_REG = 2'd0,
    SZ_I8  = 2'd1,
    SZ_I16 = 2'd2,
    SZ_I32 = 2'd3
  } imm_sz_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/eaas_imm_ext.sv
`timescale 1ns/1ps
module eaas_imm_ext
  import eaas_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHORT_W = 8,
  parameter int MID_W   = 16
) (
  input  logic [DATA_W-1:0] reg_in,
  input  logic [DATA_W-1:0] imm_in,
  input  logic [1:0]        sz_in,
  output logic [DATA_W-1:0] opnd_out
);
  localparam int PAD_S = DATA_W - SHORT_W;
  localparam int PAD_M = DATA_W - MID_W;

  logic [DATA_W-1:0] short_x;
  logic [DATA_W-1:0] mid_x;

  assign short_x = {{PAD_S{imm_in[SHORT_W-1]}}, imm_in[SHORT_W-1:0]};
  assign mid_x   = {{PAD_M{imm_in[MID_W-1]}},   imm_in[MID_W-1:0]};

  always_comb begin
    unique case (imm_sz_e'(sz_in))
      SZ_I8:   opnd_out = short_x;
      SZ_I16:  opnd_out = mid_x;
      SZ_I32:  opnd_out = imm_in;
      default: opnd_out = reg_in;
    endcase
  end
endmodule

// File: rtl/eaas_extend.sv
`timescale 1ns/1ps
module eaas_extend
  import eaas_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] val_in,
  output logic [DATA_W-1:0] ext_out,
  output logic [DATA_W-1:0] fill_out
);
  localparam int PAD_B = DATA_W - BYTE_W;
  localparam int PAD_H = DATA_W - HALF_W;

  logic sign_b;
  logic sign_h;

  assign sign_b   = val_in[BYTE_W-1];
  assign sign_h   = val_in[HALF_W-1];
  assign fill_out = {DATA_W{val_in[DATA_W-1]}};

  always_comb begin
    unique case (op_e'(op_in))
      OP_EXTB:  ext_out = {{PAD_B{sign_b}}, val_in[BYTE_W-1:0]};
      OP_EXTBU: ext_out = {{PAD_B{1'b0}},   val_in[BYTE_W-1:0]};
      OP_EXTH:  ext_out = {{PAD_H{sign_h}}, val_in[HALF_W-1:0]};
      OP_EXTHU: ext_out = {{PAD_H{1'b0}},   val_in[HALF_W-1:0]};
      default:  ext_out = '0;
    endcase
  end
endmodule

// File: rtl/eaas_addsub.sv
`timescale 1ns/1ps
module eaas_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] n_in,
  input  logic [DATA_W-1:0] m_in,
  input  logic              cin,
  input  logic              use_cin,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum_out,
  output logic              c_out,
  output logic              v_out
);
  localparam int SUM_W = DATA_W + 1;

  logic              c_eff;
  logic              c_inj;
  logic [DATA_W-1:0] m_x;
  logic [SUM_W-1:0]  wide;

  always_comb begin
    c_eff   = use_cin & cin;
    m_x     = do_sub ? ~m_in : m_in;
    c_inj   = do_sub ? ~c_eff : c_eff;
    wide    = {1'b0, n_in} + {1'b0, m_x} + {{DATA_W{1'b0}}, c_inj};
    sum_out = wide[DATA_W-1:0];
    c_out   = do_sub ? ~wide[DATA_W] : wide[DATA_W];
    v_out   = (n_in[DATA_W-1] == m_x[DATA_W-1]) &&
              (sum_out[DATA_W-1] != n_in[DATA_W-1]);
  end
endmodule

// File: rtl/eaas_top.sv
`timescale 1ns/1ps
module eaas_top
  import eaas_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [1:0]        imm_sz,
  input  logic              carry_in,
  input  logic              dst_sp,
  output logic [DATA_W-1:0] res_val,
  output logic              res_we,
  output logic [DATA_W-1:0] hi_val,
  output logic              hi_we,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_we
);
  logic [DATA_W-1:0] m_opnd;
  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] fill_val;
  logic [DATA_W-1:0] as_sum;
  logic              as_c;
  logic              as_v;
  logic              is_sub;
  logic              is_cin;
  logic              is_arith;
  logic              is_known;
  logic [DATA_W-1:0] flag_src;
  flags_t            fl;

  eaas_imm_ext #(.DATA_W(DATA_W)) u_imm (
    .reg_in   (src_val),
    .imm_in   (imm_val),
    .sz_in    (imm_sz),
    .opnd_out (m_opnd)
  );

  eaas_extend #(.DATA_W(DATA_W)) u_ext (
    .op_in    (op),
    .val_in   (dst_val),
    .ext_out  (ext_val),
    .fill_out (fill_val)
  );

  eaas_addsub #(.DATA_W(DATA_W)) u_as (
    .n_in    (dst_val),
    .m_in    (m_opnd),
    .cin     (carry_in),
    .use_cin (is_cin),
    .do_sub  (is_sub),
    .sum_out (as_sum),
    .c_out   (as_c),
    .v_out   (as_v)
  );

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SUBC);
    is_cin   = (op == OP_ADDC) || (op == OP_SUBC);
    is_arith = (op >= OP_ADD) && (op <= OP_SUBC);
    is_known = (op <= OP_SUBC);
  end

  always_comb begin
    res_val = '0;
    res_we  = 1'b0;
    hi_val  = '0;
    hi_we   = 1'b0;
    unique case (op)
      OP_EXTW: begin
        hi_val = fill_val;
        hi_we  = 1'b1;
      end
      OP_EXTB, OP_EXTBU, OP_EXTH, OP_EXTHU: begin
        res_val = ext_val;
        res_we  = 1'b1;
      end
      OP_CLR: begin
        res_val = '0;
        res_we  = 1'b1;
      end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
        res_val = as_sum;
        res_we  = 1'b1;
      end
      default: begin
        res_we = 1'b0;
      end
    endcase
  end

  always_comb begin
    flag_src = hi_we ? hi_val : res_val;
    fl.z     = ~|flag_src;
    fl.n     = flag_src[DATA_W-1];
    fl.c     = is_arith & as_c;
    fl.v     = is_arith & as_v;
    flag_z   = fl.z;
    flag_n   = fl.n;
    flag_c   = fl.c;
    flag_v   = fl.v;
    flag_we  = is_known & ~dst_sp;
  end
endmodule

// File: rtl/eaas_chk.sv
`timescale 1ns/1ps
module eaas_chk #(
  parameter int DATA_W = 32
) (
  input logic [3:0]        op,
  input logic [DATA_W-1:0] dst_val,
  input logic              dst_sp,
  input logic [DATA_W-1:0] res_val,
  input logic              res_we,
  input logic [DATA_W-1:0] hi_val,
  input logic              hi_we,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_c,
  input logic              flag_v,
  input logic              flag_we
);
  always_comb begin
    if (hi_we) begin
      a_r1_hi_fill: assert (hi_val == {DATA_W{dst_val[DATA_W-1]}} && !res_we);
    end
    if (op == 4'd5) begin
      a_r4_clear: assert (res_val == '0 && flag_z && !flag_n && !flag_c && !flag_v);
    end
    if (op <= 4'd5) begin
      a_r11_no_cv: assert (!flag_c && !flag_v);
    end
    if (dst_sp) begin
      a_r12_sp_keeps_flags: assert (!flag_we);
    end
    a_r13_one_writer: assert (!(hi_we && res_we));
    if (op > 4'd9) begin
      a_r14_no_strobes: assert (!res_we && !hi_we && !flag_we);
    end
  end
endmodule

bind eaas_top eaas_chk #(.DATA_W(DATA_W)) u_chk (
  .op      (op),
  .dst_val (dst_val),
  .dst_sp  (dst_sp),
  .res_val (res_val),
  .res_we  (res_we),
  .hi_val  (hi_val),
  .hi_we   (hi_we),
  .flag_z  (flag_z),
  .flag_n  (flag_n),
  .flag_c  (flag_c),
  .flag_v  (flag_v),
  .flag_we (flag_we)
);

// File: tb/eaas_top_tb_top.sv
`timescale 1ns/1ps
module eaas_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op;
  logic [31:0] src_val, dst_val, imm_val;
  logic [1:0]  imm_sz;
  logic        carry_in, dst_sp;
  logic [31:0] res_val, hi_val;
  logic        res_we, hi_we, flag_z, flag_n, flag_c, flag_v, flag_we;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  eaas_top dut_i (
    .op(op), .src_val(src_val), .dst_val(dst_val), .imm_val(imm_val),
    .imm_sz(imm_sz), .carry_in(carry_in), .dst_sp(dst_sp),
    .res_val(res_val), .res_we(res_we), .hi_val(hi_val), .hi_we(hi_we),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .flag_we(flag_we)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R14";
    endcase
  endfunction

  task automatic drive_and_check(input logic [3:0] o, input logic [31:0] s,
                                 input logic [31:0] d, input logic [31:0] im,
                                 input logic [1:0] sz, input logic ci,
                                 input logic sp, input string tag);
    longint unsigned m, nn, wide;
    longint sgn;
    logic [31:0] e_res, e_hi, fsrc;
    logic e_rwe, e_hwe, e_fwe, e_z, e_n, e_c, e_v;
    @(negedge clk);
    op = o; src_val = s; dst_val = d; imm_val = im; imm_sz = sz;
    carry_in = ci; dst_sp = sp;
    // operand selection (R5)
    case (sz)
      2'd1: m = longint'($signed(im[7:0])) & 64'hFFFF_FFFF;
      2'd2: m = longint'($signed(im[15:0])) & 64'hFFFF_FFFF;
      2'd3: m = im;
      default: m = s;
    endcase
    nn = d;
    e_res = 0; e_hi = 0; e_rwe = 0; e_hwe = 0; e_c = 0; e_v = 0;
    e_fwe = (o <= 4'd9) && !sp;
    case (o)
      4'd0: begin e_hwe = 1; e_hi = d[31] ? 32'hFFFF_FFFF : 32'h0; end
      4'd1: begin e_rwe = 1; e_res = 32'($signed(d[7:0])); end
      4'd2: begin e_rwe = 1; e_res = d % 256; end
      4'd3: begin e_rwe = 1; e_res = 32'($signed(d[15:0])); end
      4'd4: begin e_rwe = 1; e_res = d % 65536; end
      4'd5: begin e_rwe = 1; e_res = 0; end
      4'd6, 4'd7: begin
        e_rwe = 1;
        wide  = nn + m + ((o == 4'd7) ? longint'(ci) : 0);
        e_res = wide[31:0];
        e_c   = wide >= 64'h1_0000_0000;
        sgn   = longint'($signed(d)) + longint'($signed(m[31:0])) +
                ((o == 4'd7) ? longint'(ci) : 0);
        e_v   = (sgn > 64'sd2147483647) || (sgn < -64'sd2147483648);
      end
      4'd8, 4'd9: begin
        e_rwe = 1;
        wide  = m + ((o == 4'd9) ? longint'(ci) : 0);
        e_c   = nn < wide;
        e_res = 32'(nn - wide);
        sgn   = longint'($signed(d)) - longint'($signed(m[31:0])) -
                ((o == 4'd9) ? longint'(ci) : 0);
        e_v   = (sgn > 64'sd2147483647) || (sgn < -64'sd2147483648);
      end
      default: ;
    endcase
    fsrc = e_hwe ? e_hi : e_res;
    e_z = (fsrc == 0);
    e_n = fsrc[31];
    @(posedge clk);
    #2;
    checks++;
    if (res_we !== e_rwe || hi_we !== e_hwe || flag_we !== e_fwe ||
        (e_rwe && res_val !== e_res) || (e_hwe && hi_val !== e_hi) ||
        (o <= 4'd9 && {flag_z, flag_n, flag_c, flag_v} !== {e_z, e_n, e_c, e_v})) begin
      errors++;
      $display("FAIL %s op=%0d: got res=%h we=%b hi=%h hwe=%b zncv=%b%b%b%b fwe=%b, expected res=%h we=%b hi=%h hwe=%b zncv=%b%b%b%b fwe=%b",
               tag, o, res_val, res_we, hi_val, hi_we, flag_z, flag_n, flag_c, flag_v,
               flag_we, e_res, e_rwe, e_hi, e_hwe, e_z, e_n, e_c, e_v, e_fwe);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    op = 4'hF; src_val = 0; dst_val = 0; imm_val = 0; imm_sz = 0;
    carry_in = 0; dst_sp = 0;
    repeat (3) @(posedge clk);
    // reset state: idle code drives no strobe (R14)
    #2; checks++;
    if (res_we || hi_we || flag_we) begin
      errors++;
      $display("FAIL R14 reset idle: got %b%b%b expected 000", res_we, hi_we, flag_we);
    end
    rst_n = 1'b1;

    drive_and_check(0, 0, 32'h8000_0001, 0, 0, 0, 0, "R1");
    drive_and_check(0, 0, 32'h7FFF_FFFF, 0, 0, 1, 0, "R1 R11");
    drive_and_check(1, 0, 32'h1234_5680, 0, 0, 1, 0, "R2 R11");
    drive_and_check(2, 0, 32'hFFFF_FF80, 0, 0, 0, 0, "R2");
    drive_and_check(3, 0, 32'hABCD_8001, 0, 0, 0, 0, "R3");
    drive_and_check(4, 0, 32'hABCD_8001, 0, 0, 0, 0, "R3");
    drive_and_check(3, 0, 32'hFFFF_7FFF, 0, 0, 0, 0, "R3");
    drive_and_check(5, 0, 32'hDEAD_BEEF, 0, 0, 1, 0, "R4");
    drive_and_check(6, 0, 32'h10, 32'h1234_56FF, 1, 1, 0, "R5 R6");
    drive_and_check(6, 0, 32'h10, 32'h1234_8000, 2, 0, 0, "R5");
    drive_and_check(6, 0, 32'h10, 32'h8000_0000, 3, 0, 0, "R5");
    drive_and_check(6, 32'hFFFF_FFFF, 32'h1, 0, 0, 1, 0, "R6");
    drive_and_check(6, 32'h1, 32'h7FFF_FFFF, 0, 0, 0, 0, "R10");
    drive_and_check(7, 32'hFFFF_FFFF, 32'h0, 0, 0, 1, 0, "R7");
    drive_and_check(7, 32'h5, 32'h6, 0, 0, 1, 0, "R7");
    drive_and_check(8, 32'h1, 32'h0, 0, 0, 1, 0, "R8");
    drive_and_check(8, 32'h5, 32'h5, 0, 0, 1, 0, "R8");
    drive_and_check(8, 32'h3, 32'h10, 0, 0, 0, 0, "R8");
    drive_and_check(8, 32'h1, 32'h8000_0000, 0, 0, 0, 0, "R10");
    drive_and_check(9, 32'h5, 32'h5, 0, 0, 1, 0, "R9");
    drive_and_check(9, 32'h5, 32'h6, 0, 0, 1, 0, "R9");
    drive_and_check(6, 0, 32'h4, 32'hFC, 1, 0, 1, "R12");
    drive_and_check(1, 0, 32'h80, 0, 0, 0, 1, "R12");
    drive_and_check(0, 0, 32'h8000_0000, 0, 0, 0, 0, "R13");
    drive_and_check(4'd10, 1, 2, 3, 0, 1, 0, "R14");
    drive_and_check(4'd15, 1, 2, 3, 3, 0, 0, "R14");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 11));
      drive_and_check(ro, $urandom, $urandom, $urandom, 2'($urandom),
                      1'($urandom), 1'($urandom_range(0, 3) == 0), tag_of(ro));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule